// File: doc/BRIEF.md
# Multi-mode load instruction sequencer

This block is the step-by-step control unit and register set of a small single-bus processor that knows one instruction: a load. Each instruction is fetched from a word-addressed memory port and decoded. Its operand address is then resolved in one of three ways. Direct mode uses the address field as the operand address. Memory-indirect mode reads a pointer word at the address field and then reads the operand at that pointer. Register-indirect mode takes the operand address from a register. The operand is written into a destination register.

Each memory access raises a read request and holds it, with the address steady, until the memory answers with a completion strobe. The memory may answer in the first request cycle or after any number of wait cycles. The block brings out the current step number and the control strobes of each step, including the register-file write and an end-of-instruction pulse. A bus monitor or a trace unit can follow the execution from these. The instruction sequence has no fixed length: it depends on the addressing mode and on the memory wait cycles.

Top module: `ldseq_top`

## Requirements
- R1: After reset the program counter is 0. Every fetch reads the word at the current program counter and advances the counter by exactly one, so successive fetch addresses are 0, 1, 2, ... The `pc_inc` strobe is high in every cycle where `step` is 0.
- R2: The read request `mem_rd` stays high, with `mem_addr` unchanged, until `mem_mfc` is sampled high. The sequencer does not leave its wait step before that. A completion in the first request cycle (zero extra wait cycles) is accepted.
- R3: The instruction word has four fields: bits [15:14] hold the mode (00 direct, 01 memory-indirect, 10 register-indirect, 11 no-op), bits [13:12] the destination register, bits [11:10] the source register and bits [9:0] the address field.
- R4: In direct mode the operand is read at the address field.
- R5: In memory-indirect mode the block reads the word at the address field, then reads the operand at bits [9:0] of that word. The upper bits of the pointer word are ignored.
- R6: In register-indirect mode the operand is read at bits [9:0] of the source register, and the address field is ignored. A register value written by an earlier load is the one used.
- R7: The register write happens in the last step of a load. In that single cycle `rf_we` and `instr_end` are both high, `rf_wsel` is the destination register and `rf_wdata` is the operand. `rf_we` is never high at any other time.
- R8: With no wait cycles, a direct or register-indirect load takes 6 cycles, a memory-indirect load takes 8 and a no-op takes 4. Each memory wait cycle adds one cycle. `instr_end` is high for the last cycle only, and the next cycle is step 0 of the next fetch.
- R9: Mode 11 ends the instruction right after decode. It makes no operand read and no register write, and the destination register keeps its value.
- R10: While reset is high, `step` is 0 and `mem_rd`, `instr_end` and `rf_we` are low. The first fetch starts in the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 10 | Memory word address (the address register) |
| mem_rd | output | 1 | Read request, held until completion |
| mem_rdata | input | 16 | Read data, valid when `mem_mfc` is high |
| mem_mfc | input | 1 | Memory completion strobe |
| step | output | 3 | Current step number (0 = fetch) |
| pc_inc | output | 1 | Program counter copied to the address register and incremented |
| mar_ld | output | 1 | Address register loaded with an operand-side address |
| ir_ld | output | 1 | Instruction register loaded from the data register |
| rf_we | output | 1 | Register-file write strobe |
| rf_wsel | output | 2 | Register written |
| rf_wdata | output | 16 | Data written |
| instr_end | output | 1 | Last cycle of the current instruction |

## Verification
An internal fault shows up at the memory port within one access. A wrong program counter or a wrong address mux selection gives a wrong `mem_addr` when the next read completes. A wrong step transition changes the distance between `instr_end` pulses or puts the wrong number of reads into an instruction. A wrong data capture or register-file fault shows in `rf_wdata` at the end of the same load. It also shows later as a wrong address in a register-indirect load that uses that register. The scoreboard compares every completed read and every end pulse against a model of the program, and memory latency varies by address between zero and two wait cycles.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_FWAIT   = 3'd1,
    ST_DECODE  = 3'd2,
    ST_ADDR    = 3'd3,
    ST_PTRWAIT = 3'd4,
    ST_PTRADDR = 3'd5,
    ST_OPWAIT  = 3'd6,
    ST_WB      = 3'd7
  } step_e;

  localparam logic [1:0] MD_DIRECT = 2'b00;
  localparam logic [1:0] MD_INDIR  = 2'b01;
  localparam logic [1:0] MD_REGIND = 2'b10;
  localparam logic [1:0] MD_NOP    = 2'b11;

  typedef enum logic [1:0] {
    MS_FIELD = 2'd0,
    MS_REG   = 2'd1,
    MS_MDR   = 2'd2
  } msel_e;

  typedef struct packed {
    logic  pc_step;
    logic  mar_ld;
    msel_e mar_sel;
    logic  rd;
    logic  ir_ld;
    logic  rf_we;
    logic  fin;
  } ctl_t;

  // Control vector of a step; mode only matters for the address step.
  function automatic ctl_t ctl_for(step_e s, logic [1:0] mode);
    ctl_t c;
    c = '0;
    unique case (s)
      ST_FETCH:   c.pc_step = 1'b1;
      ST_FWAIT,
      ST_PTRWAIT,
      ST_OPWAIT:  c.rd = 1'b1;
      ST_DECODE:  c.ir_ld = 1'b1;
      ST_ADDR: begin
        unique case (mode)
          MD_DIRECT, MD_INDIR: begin c.mar_ld = 1'b1; c.mar_sel = MS_FIELD; end
          MD_REGIND:           begin c.mar_ld = 1'b1; c.mar_sel = MS_REG;   end
          default:             c.fin = 1'b1;
        endcase
      end
      ST_PTRADDR: begin c.mar_ld = 1'b1; c.mar_sel = MS_MDR; end
      ST_WB:      begin c.rf_we = 1'b1; c.fin = 1'b1; end
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ldseq_ctrl.sv
module ldseq_ctrl
  import ldseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mfc,
  input  logic [1:0] fetched_mode,
  input  logic [1:0] ir_mode,
  output step_e      step,
  output ctl_t       ctl
);

  step_e      nxt;
  logic [1:0] mode_sel;

  always_comb begin
    nxt = step;
    unique case (step)
      ST_FETCH:   nxt = ST_FWAIT;
      ST_FWAIT:   if (mfc) nxt = ST_DECODE;
      ST_DECODE:  nxt = ST_ADDR;
      ST_ADDR: begin
        unique case (ir_mode)
          MD_DIRECT, MD_REGIND: nxt = ST_OPWAIT;
          MD_INDIR:             nxt = ST_PTRWAIT;
          default:              nxt = ST_FETCH;
        endcase
      end
      ST_PTRWAIT: if (mfc) nxt = ST_PTRADDR;
      ST_PTRADDR: nxt = ST_OPWAIT;
      ST_OPWAIT:  if (mfc) nxt = ST_WB;
      ST_WB:      nxt = ST_FETCH;
      default:    nxt = ST_FETCH;
    endcase
  end

  // Entering the address step, the instruction is still in the data register.
  assign mode_sel = (step == ST_DECODE) ? fetched_mode : ir_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_FETCH;
      ctl  <= ctl_for(ST_FETCH, MD_DIRECT);
    end else begin
      step <= nxt;
      ctl  <= ctl_for(nxt, mode_sel);
    end
  end

  AST_WAIT_HOLDS_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctl.rd && !mfc) |=> (step == $past(step))); // R2
  AST_NOP_ENDS_EARLY: assert property (@(posedge clk) disable iff (rst)
    (step == ST_ADDR && ir_mode == MD_NOP) |-> (ctl.fin && !ctl.mar_ld && !ctl.rf_we)); // R9
  AST_END_RETURNS_TO_FETCH: assert property (@(posedge clk) disable iff (rst)
    ctl.fin |=> (step == ST_FETCH && !ctl.fin)); // R8
  AST_WB_FOLLOWS_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (step == ST_WB) |-> ($past(step) == ST_OPWAIT)); // R7

endmodule

// File: rtl/ldseq_datapath.sv
module ldseq_datapath
  import ldseq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic          mfc,
  input  logic [DW-1:0] rdata,
  input  logic [AW-1:0] reg_ptr,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir
);

  logic [AW-1:0] mar_src;

  always_comb begin
    unique case (ctl.mar_sel)
      MS_REG:  mar_src = reg_ptr;
      MS_MDR:  mar_src = mdr[AW-1:0];
      default: mar_src = ir[AW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (ctl.pc_step) begin
        mar <= pc;
        pc  <= pc + AW'(1);
      end else if (ctl.mar_ld) begin
        mar <= mar_src;
      end
      if (ctl.rd && mfc) mdr <= rdata;
      if (ctl.ir_ld)     ir  <= mdr;
    end
  end

  AST_PC_ADVANCES_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_step |=> (pc == $past(pc) + AW'(1))); // R1
  AST_ADDR_STEADY_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (ctl.rd && !mfc) |=> (ctl.rd && mar == $past(mar))); // R2

endmodule

// File: rtl/ldseq_regfile.sv
module ldseq_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  parameter int OW   = 10,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr,
  output logic [OW-1:0] rptr
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rptr = regs[raddr][OW-1:0];

endmodule

// File: rtl/ldseq_top.sv
module ldseq_top
  import ldseq_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_mfc,
  output logic [2:0]    step,
  output logic          pc_inc,
  output logic          mar_ld,
  output logic          ir_ld,
  output logic          rf_we,
  output logic [RW-1:0] rf_wsel,
  output logic [DW-1:0] rf_wdata,
  output logic          instr_end
);

  localparam int MODE_HI = DW - 1;
  localparam int DST_LO  = AW + RW;
  localparam int SRC_LO  = AW;

  step_e         st;
  ctl_t          ctl;
  logic [AW-1:0] pc, mar, reg_ptr;
  logic [DW-1:0] mdr, ir;

  ldseq_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .mfc          (mem_mfc),
    .fetched_mode (mdr[MODE_HI -: 2]),
    .ir_mode      (ir[MODE_HI -: 2]),
    .step         (st),
    .ctl          (ctl)
  );

  ldseq_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .mfc     (mem_mfc),
    .rdata   (mem_rdata),
    .reg_ptr (reg_ptr),
    .pc      (pc),
    .mar     (mar),
    .mdr     (mdr),
    .ir      (ir)
  );

  ldseq_regfile #(.DW(DW), .NREG(NREG), .OW(AW)) u_rf (
    .clk   (clk),
    .we    (ctl.rf_we),
    .waddr (ir[DST_LO +: RW]),
    .wdata (mdr),
    .raddr (ir[SRC_LO +: RW]),
    .rptr  (reg_ptr)
  );

  assign mem_addr  = mar;
  assign mem_rd    = ctl.rd;
  assign step      = st;
  assign pc_inc    = ctl.pc_step;
  assign mar_ld    = ctl.mar_ld;
  assign ir_ld     = ctl.ir_ld;
  assign rf_we     = ctl.rf_we;
  assign rf_wsel   = ir[DST_LO +: RW];
  assign rf_wdata  = mdr;
  assign instr_end = ctl.fin;

  AST_WRITE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> instr_end); // R7
  AST_FETCH_STEP_INCREMENTS: assert property (@(posedge clk) disable iff (rst)
    (step == 3'd0) |-> (pc_inc && !mem_rd)); // R1

endmodule

// File: tb/tb_ldseq_top.sv
module tb_ldseq_top;

  localparam int NINSTR = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata;
  logic        mem_mfc;
  logic [2:0]  step;
  logic        pc_inc, mar_ld, ir_ld, rf_we, instr_end;
  logic [1:0]  rf_wsel;
  logic [15:0] rf_wdata;

  always #5 clk = ~clk;

  ldseq_top dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_mfc(mem_mfc), .step(step), .pc_inc(pc_inc),
    .mar_ld(mar_ld), .ir_ld(ir_ld), .rf_we(rf_we), .rf_wsel(rf_wsel),
    .rf_wdata(rf_wdata), .instr_end(instr_end)
  );

  // Memory model: latency 0..2 wait cycles chosen by address.
  logic [15:0] mem [1024];
  int          wcnt;

  function automatic int lat(logic [9:0] a);
    return int'(a) % 3;
  endfunction

  always @(posedge clk) begin
    if (!mem_rd) wcnt <= 0;
    else         wcnt <= wcnt + 1;
  end
  assign mem_mfc   = mem_rd && (wcnt == lat(mem_addr));
  assign mem_rdata = mem[mem_addr];

  // Scoreboard
  typedef struct {
    bit          is_end;
    logic [9:0]  addr;
    bit          we;
    logic [1:0]  sel;
    logic [15:0] data;
    int          cyc;
    string       req;
  } item_t;

  item_t       expq[$];
  logic [15:0] mrf [4];
  int          checks = 0;
  int          fails = 0;
  int          ends_seen = 0;
  int          cyc = 0;
  bit          prev_wait = 0;
  logic [9:0]  prev_addr = '0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_rd(logic [9:0] a, string req);
    item_t it;
    it = '{is_end: 0, addr: a, we: 0, sel: 0, data: 0, cyc: 0, req: req};
    expq.push_back(it);
  endtask

  // Driver: models one instruction at address pc and pushes expected items.
  task automatic model_instr(logic [9:0] pc);
    logic [15:0] w, x;
    logic [9:0]  oa;
    int          n;
    item_t       it;
    w = mem[pc];
    push_rd(pc, "R1");
    n = 4 + lat(pc);
    it = '{is_end: 1, addr: 0, we: 0, sel: w[13:12], data: 0, cyc: 0, req: "R8"};
    case (w[15:14])
      2'b00: begin oa = w[9:0]; push_rd(oa, "R4"); n += 2 + lat(oa); end
      2'b01: begin
        push_rd(w[9:0], "R5");
        x  = mem[w[9:0]];
        oa = x[9:0];
        push_rd(oa, "R5");
        n += 4 + lat(w[9:0]) + lat(oa);
      end
      2'b10: begin oa = mrf[w[11:10]][9:0]; push_rd(oa, "R6"); n += 2 + lat(oa); end
      default: begin it.req = "R9"; oa = '0; end
    endcase
    if (w[15:14] != 2'b11) begin
      it.we   = 1;
      it.data = mem[oa];
      mrf[w[13:12]] = mem[oa];
      it.req  = "R7";
    end
    it.cyc = n;
    expq.push_back(it);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && ends_seen < NINSTR) begin
      item_t it;
      cyc++;
      if (prev_wait)
        chk(mem_rd && mem_addr == prev_addr, "R2", "request held with steady address",
            {21'd0, mem_rd, mem_addr}, {21'd0, 1'b1, prev_addr});
      if (step == 3'd0)
        chk(pc_inc == 1'b1, "R1", "pc_inc in fetch step", pc_inc, 1);
      if (rf_we && !instr_end)
        chk(0, "R7", "write outside end cycle", rf_we, 0);
      if (mem_rd && mem_mfc) begin
        if (expq.size() == 0) chk(0, "R4", "unexpected read", mem_addr, 0);
        else begin
          it = expq.pop_front();
          chk(!it.is_end, it.req, "read where end expected", 1, 0);
          chk(mem_addr == it.addr, it.req, "read address", mem_addr, it.addr);
        end
      end
      if (instr_end) begin
        if (expq.size() == 0) chk(0, "R8", "unexpected end", 1, 0);
        else begin
          it = expq.pop_front();
          chk(it.is_end, "R8", "end where read expected", 0, 1);
          chk(rf_we == it.we, it.we ? "R7" : "R9", "write strobe", rf_we, it.we);
          if (it.we) begin
            chk(rf_wsel == it.sel, "R7", "write register", rf_wsel, it.sel);
            chk(rf_wdata == it.data, it.req, "write data", rf_wdata, it.data);
          end
          chk(cyc == it.cyc, "R8", "instruction length", cyc, it.cyc);
        end
        cyc = 0;
        ends_seen++;
      end
      prev_wait = mem_rd && !mem_mfc;
      prev_addr = mem_addr;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    // Program: {mode[15:14], dst[13:12], src[11:10], M[9:0]}
    mem[0] = {2'b00, 2'd1, 2'd0, 10'h100};  // R4 direct -> R1
    mem[1] = {2'b00, 2'd2, 2'd0, 10'h101};  // R4 direct -> R2
    mem[2] = {2'b01, 2'd3, 2'd0, 10'h102};  // R5 indirect -> R3
    mem[3] = {2'b10, 2'd0, 2'd2, 10'h000};  // R6 via R2 -> R0
    mem[4] = {2'b11, 2'd0, 2'd1, 10'h155};  // R9 no-op naming R0
    mem[5] = {2'b10, 2'd1, 2'd0, 10'h000};  // R6 via R0 (shows R0 kept)
    mem[6] = {2'b10, 2'd3, 2'd1, 10'h3AA};  // R6 field ignored
    mem[7] = {2'b01, 2'd1, 2'd0, 10'h103};  // R5 pointer upper bits ignored
    mem[8] = {2'b00, 2'd0, 2'd0, 10'h3FF};  // R4 top address
    mem[9] = {2'b10, 2'd2, 2'd2, 10'h000};  // R6 src equals dst
    mem[10'h100] = 16'h0205;
    mem[10'h101] = 16'h0300;
    mem[10'h102] = 16'h0180;
    mem[10'h180] = 16'hBEEF;
    mem[10'h300] = 16'h1234;
    mem[10'h234] = 16'h4321;
    mem[10'h321] = 16'hA5A5;
    mem[10'h103] = 16'hFC10;
    mem[10'h010] = 16'h7777;
    mem[10'h3FF] = 16'hFFFF;
    for (int r = 0; r < 4; r++) mrf[r] = 16'h0000;
    for (int p = 0; p < NINSTR; p++) model_instr(10'(p));

    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(step == 3'd0, "R10", "step in reset", step, 0);
    chk(!mem_rd && !instr_end && !rf_we, "R10", "strobes in reset",
        {mem_rd, instr_end, rf_we}, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
  end

  initial begin
    int n;
    n = 0;
    while (ends_seen < NINSTR && n < 5000) begin
      @(posedge clk);
      n++;
    end
    repeat (2) @(posedge clk);
    if (ends_seen < NINSTR) chk(0, "R8", "watchdog expired, instructions ended", ends_seen, NINSTR);
    chk(expq.size() == 0, "R8", "scoreboard drained", expq.size(), 0);
    finish_run();
  end

endmodule